// File: doc/BRIEF.md
# Chained Descriptor Ring Fetcher (receive direction)

This block is the front end of the receive DMA of an Ethernet MAC. Software builds a ring of four-word descriptors in memory, each holding a status word, a buffer-size word, a buffer pointer and a pointer to the next descriptor. Software programs a base address and raises the run enable. The block then walks the ring by following the stored next pointers. For each descriptor that hardware owns, it hands the buffer pointer and size to the data mover. When the mover finishes, the block writes the status back and returns ownership to software.

When the block reads a descriptor that software still owns, it parks. It leaves the park state only on a poll-demand strobe, which makes it re-read the same descriptor. Segment flags and the running frame length are kept across buffers, so a frame that spans several buffers is marked first and last, and its full length is reported on the last descriptor. A per-descriptor quiet bit suppresses the completion pulse.

Controller states and transitions:
- IDLE, shown as stopped: run_en moves it to FETCH and reloads the pointer from the base.
- FETCH: reads the four words in order. A clear ownership bit in word 0 moves it to PARK, or to IDLE when run_en is low. The fourth response moves it to LAUNCH.
- LAUNCH: one cycle of mv_start, then MOVE.
- MOVE: mv_done moves it to WBACK.
- WBACK: the write response moves it to FETCH of the next descriptor, or to IDLE when run_en is low.
- PARK: poll_kick moves it to FETCH. A low run_en moves it to IDLE.

Top module: `dring_fetch`

## Requirements
- R1: When run_en is high in the stopped state, the next cycle shows state_code 1 and a read request at base_addr. Every restart reloads the pointer from base_addr.
- R2: A descriptor is read as four single-word reads at its address plus 0, 4, 8 and 12, in that order. mv_start then pulses with mv_addr taken from word 2 and mv_size taken from word 1 bits 12:0.
- R3: The following descriptor is read at the address held in word 3 of the current one, not at the next contiguous address.
- R4: If word 0 bit 31 (ownership) is clear, the block parks: state_code reads 3, no further request is made and the mover is not started.
- R5: A poll_kick while parked re-reads the same descriptor. The next cycle shows state_code 1 with a read at the same address. If ownership is still clear, the block parks again.
- R6: After mv_done, the block writes word 0 of the same descriptor. The written word has bit 31 clear, bit 9 set when the buffer is the first of a frame, and bit 8 set when mv_eop was high. All other bits are zero except the length field.
- R7: The written word carries the frame length in bits 29:16: the sum of mv_bytes over all buffers of the frame, including the 4-byte CRC. The field is zero when mv_eop is low.
- R8: done_irq pulses for one cycle, one cycle after the write response, unless word 1 bit 31 (quiet) of that descriptor is set.
- R9: If run_en is cleared while a buffer is in flight, that descriptor is still written back. The block then shows state_code 0 and issues no further requests.
- R10: If run_en is low while parked, the block shows state_code 0 on the next cycle.
- R11: state_code encodes the state as 0 stopped, 1 fetching, 2 running (launch, move or write-back), 3 parked. After reset it reads 0 with no request, no mv_start and no done_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Engine run enable |
| poll_kick | input | 1 | Poll-demand strobe |
| base_addr | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | One-cycle response to the request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mv_start | output | 1 | One-cycle start to the data mover |
| mv_addr | output | AW | Buffer pointer for the mover |
| mv_size | output | 13 | Buffer size for the mover |
| mv_done | input | 1 | Mover finished the buffer |
| mv_bytes | input | 14 | Bytes placed in the buffer, valid with mv_done |
| mv_eop | input | 1 | Buffer ends the frame, valid with mv_done |
| done_irq | output | 1 | Completion pulse |
| state_code | output | 2 | Engine state code |

## Verification
A state transition is seen on state_code one cycle after its cause. This covers run_en from stopped, poll_kick while parked, the ownership-clear read response, the final write response and a low run_en while parked. A read request at the new address is visible in that same cycle. mv_start rises in the cycle after the fourth read response. done_irq follows the write response by exactly one cycle. The bench samples on the falling edge. It first waits for the triggering event (a read or write response, or mv_start), then checks either at that falling edge or at the one after it, as each result requires.

// File: rtl/dring_pkg.sv
package dring_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_LAUNCH, S_MOVE, S_WBACK, S_PARK
    } dstate_t;

    localparam int DW         = 32;
    localparam int OWN_BIT    = 31;
    localparam int QUIET_BIT  = 31;
    localparam int FSEG_BIT   = 9;
    localparam int LSEG_BIT   = 8;
    localparam int LEN_LSB    = 16;
    localparam int LEN_W      = 14;
    localparam int SIZE_W     = 13;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    localparam logic [1:0] CODE_STOP  = 2'd0;
    localparam logic [1:0] CODE_FETCH = 2'd1;
    localparam logic [1:0] CODE_RUN   = 2'd2;
    localparam logic [1:0] CODE_PARK  = 2'd3;
endpackage

// File: rtl/dring_desc_regs.sv
module dring_desc_regs
    import dring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [IDX_W-1:0]     idx,
    input  logic [DW-1:0]        rdata,
    output logic [SIZE_W-1:0]    buf_size,
    output logic                 quiet,
    output logic [AW-1:0]        buf_ptr,
    output logic [AW-1:0]        next_ptr
);
    // Word 0 is consumed on the fly by the controller; words 1..3 are held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_size <= '0;
            quiet    <= 1'b0;
            buf_ptr  <= '0;
            next_ptr <= '0;
        end else if (load) begin
            unique case (idx)
                IDX_W'(1): begin
                    buf_size <= rdata[SIZE_W-1:0];
                    quiet    <= rdata[QUIET_BIT];
                end
                IDX_W'(2): buf_ptr  <= rdata[AW-1:0];
                IDX_W'(3): next_ptr <= rdata[AW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dring_seg_track.sv
module dring_seg_track
    import dring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              mv_done,
    input  logic [LEN_W-1:0]  mv_bytes,
    input  logic              mv_eop,
    input  logic              commit,
    output logic              first_seg,
    output logic              last_seg,
    output logic [LEN_W-1:0]  frame_len
);
    logic [LEN_W-1:0] run_len_q;
    logic [LEN_W-1:0] bytes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_seg <= 1'b1;
            run_len_q <= '0;
            bytes_q   <= '0;
            last_seg  <= 1'b0;
        end else begin
            if (mv_done) begin
                bytes_q  <= mv_bytes;
                last_seg <= mv_eop;
            end
            if (restart) begin
                first_seg <= 1'b1;
                run_len_q <= '0;
            end else if (commit) begin
                first_seg <= last_seg;
                run_len_q <= last_seg ? '0 : run_len_q + bytes_q;
            end
        end
    end

    assign frame_len = run_len_q + bytes_q;
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
    import dring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              poll_kick,
    input  logic [AW-1:0]     base_addr,
    input  logic              mem_ack,
    input  logic              own_bit,
    input  logic [AW-1:0]     next_ptr,
    input  logic              quiet,
    input  logic              mv_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic              word_load,
    output logic [IDX_W-1:0]  word_idx,
    output logic              mv_start,
    output logic              restart,
    output logic              commit,
    output logic              done_irq,
    output logic [1:0]        state_code
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    dstate_t          state_q, state_d;
    logic [AW-1:0]    ptr_q;
    logic [IDX_W-1:0] idx_q;
    logic             irq_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (run_en) state_d = S_FETCH;
            S_FETCH: begin
                if (mem_ack) begin
                    if (idx_q == '0 && !own_bit) state_d = run_en ? S_PARK : S_IDLE;
                    else if (idx_q == LAST_IDX)  state_d = S_LAUNCH;
                end
            end
            S_LAUNCH: state_d = S_MOVE;
            S_MOVE:   if (mv_done) state_d = S_WBACK;
            S_WBACK:  if (mem_ack) state_d = run_en ? S_FETCH : S_IDLE;
            S_PARK: begin
                if (!run_en)        state_d = S_IDLE;
                else if (poll_kick) state_d = S_FETCH;
            end
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = (state_q == S_FETCH) || (state_q == S_WBACK);
        mem_we    = (state_q == S_WBACK);
        mem_addr  = ptr_q + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};
        word_load = (state_q == S_FETCH) && mem_ack;
        word_idx  = idx_q;
        mv_start  = (state_q == S_LAUNCH);
        restart   = (state_q == S_IDLE) && run_en;
        commit    = (state_q == S_WBACK) && mem_ack;
        done_irq  = irq_q;
        unique case (state_q)
            S_IDLE:  state_code = CODE_STOP;
            S_FETCH: state_code = CODE_FETCH;
            S_PARK:  state_code = CODE_PARK;
            default: state_code = CODE_RUN;
        endcase
    end

    // Descriptor pointer, word index and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= commit && !quiet;
            if (restart) begin
                ptr_q <= base_addr;
                idx_q <= '0;
            end else if (word_load) begin
                idx_q <= (idx_q == '0 && !own_bit) ? '0 : idx_q + 1'b1;
            end else if (commit) begin
                ptr_q <= next_ptr;
            end
        end
    end
endmodule

// File: rtl/dring_fetch.sv
module dring_fetch
    import dring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              poll_kick,
    input  logic [AW-1:0]     base_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mv_start,
    output logic [AW-1:0]     mv_addr,
    output logic [SIZE_W-1:0] mv_size,
    input  logic              mv_done,
    input  logic [LEN_W-1:0]  mv_bytes,
    input  logic              mv_eop,
    output logic              done_irq,
    output logic [1:0]        state_code
);
    logic             word_load, restart, commit, quiet;
    logic [IDX_W-1:0] word_idx;
    logic [AW-1:0]    next_ptr;
    logic             first_seg, last_seg;
    logic [LEN_W-1:0] frame_len;

    dring_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_kick(poll_kick),
        .base_addr(base_addr), .mem_ack(mem_ack), .own_bit(mem_rdata[OWN_BIT]),
        .next_ptr(next_ptr), .quiet(quiet), .mv_done(mv_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .word_load(word_load), .word_idx(word_idx), .mv_start(mv_start),
        .restart(restart), .commit(commit), .done_irq(done_irq),
        .state_code(state_code)
    );

    dring_desc_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(word_load), .idx(word_idx),
        .rdata(mem_rdata), .buf_size(mv_size), .quiet(quiet),
        .buf_ptr(mv_addr), .next_ptr(next_ptr)
    );

    dring_seg_track u_seg (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mv_done(mv_done),
        .mv_bytes(mv_bytes), .mv_eop(mv_eop), .commit(commit),
        .first_seg(first_seg), .last_seg(last_seg), .frame_len(frame_len)
    );

    // Status word returned to software: ownership cleared
    always_comb begin
        mem_wdata = '0;
        mem_wdata[LEN_LSB +: LEN_W] = last_seg ? frame_len : '0;
        mem_wdata[FSEG_BIT] = first_seg;
        mem_wdata[LSEG_BIT] = last_seg;
    end
endmodule

// File: rtl/dring_fetch_chk.sv
module dring_fetch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_en,
    input logic        poll_kick,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_wdata,
    input logic        mv_start,
    input logic        done_irq,
    input logic [1:0]  state_code
);
    a_r2_launch_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> $past(mem_ack && !mem_we));

    a_r4_park_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_code == 2'd3) |-> $past(mem_ack && !mem_we));

    a_r5_poll_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd3 && poll_kick && run_en) |=> (state_code == 2'd1 && mem_req && !mem_we));

    a_r6_own_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    a_r8_irq_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(mem_ack && mem_we));

    a_r9_stop_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && mem_ack && mem_we) |=> (state_code == 2'd0));

    a_r10_park_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd3 && !run_en) |=> (state_code == 2'd0));

    a_r11_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);
endmodule

bind dring_fetch dring_fetch_chk u_chk (.*);

// File: tb/dring_fetch_bench.sv
module dring_fetch_bench;
    localparam int LAT = 2;
    localparam int NV  = 6;
    // {quiet, eop, bytes[13:0], size[12:0]}
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 1'b1, 14'd100, 13'd1536},
        {1'b0, 1'b0, 14'd256, 13'd256},
        {1'b1, 1'b0, 14'd256, 13'd256},
        {1'b0, 1'b1, 14'd60,  13'd512},
        {1'b1, 1'b1, 14'd64,  13'd128},
        {1'b0, 1'b1, 14'd200, 13'd800}
    };
    localparam logic [31:0] RING [4] = '{32'h40, 32'h70, 32'h50, 32'h60};

    logic clk = 1'b0, rst_n = 1'b0;
    logic run_en = 1'b0, poll_kick = 1'b0;
    logic [31:0] base_addr = 32'h40;
    logic mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic mv_start, mv_done, mv_eop, done_irq;
    logic [31:0] mv_addr;
    logic [12:0] mv_size;
    logic [13:0] mv_bytes;
    logic [1:0] state_code;
    logic [13:0] nxt_bytes = '0;
    logic nxt_eop = 1'b0;

    int total = 0, fails = 0, mv_starts = 0, mv_cnt = 0, lat = 0;
    logic [31:0] mem [0:255];

    always #5 clk = ~clk;

    dring_fetch u_dring_fetch (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_kick(poll_kick),
        .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mv_start(mv_start), .mv_addr(mv_addr),
        .mv_size(mv_size), .mv_done(mv_done), .mv_bytes(mv_bytes),
        .mv_eop(mv_eop), .done_irq(done_irq), .state_code(state_code)
    );

    // Memory model: fixed latency, one-cycle response
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; lat <= 0; mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat == LAT) begin
                lat <= 0; mem_ack <= 1'b1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            end else lat <= lat + 1;
        end
    end

    // Data mover model
    assign mv_bytes = nxt_bytes;
    assign mv_eop   = nxt_eop;
    always @(posedge clk) begin
        if (!rst_n) begin
            mv_done <= 1'b0; mv_cnt <= 0;
        end else begin
            mv_done <= 1'b0;
            if (mv_start) begin
                mv_cnt <= 3; mv_starts <= mv_starts + 1;
            end else if (mv_cnt != 0) begin
                mv_cnt <= mv_cnt - 1;
                if (mv_cnt == 1) mv_done <= 1'b1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic arm(input int k, input logic [12:0] size, input logic quiet);
        mem[RING[k][9:2]]     <= 32'h8000_0000;
        mem[RING[k][9:2] + 1] <= {quiet, 18'd0, size};
        mem[RING[k][9:2] + 2] <= 32'h1000 + k * 32'h800;
        mem[RING[k][9:2] + 3] <= RING[(k + 1) % 4];
    endtask

    function automatic logic [31:0] status(input logic fs, input logic ls, input logic [13:0] len);
        return {2'b00, len, 6'd0, fs, ls, 8'd0};
    endfunction

    task automatic wait_start();
        do @(negedge clk); while (!mv_start);
    endtask
    task automatic wait_wb();
        do @(negedge clk); while (!(mem_ack && mem_we));
    endtask
    task automatic wait_rd();
        do @(negedge clk); while (!(mem_ack && !mem_we));
    endtask
    task automatic kick();
        poll_kick = 1'b1;
        @(negedge clk);
        poll_kick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic first;
        logic [13:0] acc;
        for (int i = 0; i < 256; i++) mem[i] <= '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 reset state_code", 32'(state_code), 32'd0);
        check("R11 reset mem_req", 32'(mem_req), 32'd0);
        check("R11 reset mv_start/irq", {30'd0, mv_start, done_irq}, 32'd0);
        for (int k = 0; k < 4; k++) arm(k, VEC[k][12:0], VEC[k][28]);
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        check("R1 start state_code", 32'(state_code), 32'd1);
        check("R1 first read at base", mem_addr, 32'h40);
        for (int j = 0; j < 4; j++) begin
            wait_rd();
            check("R2 word read order", mem_addr, 32'h40 + 4 * j);
        end
        // Vector walk: R2 R3 R6 R7 R8
        first = 1'b1; acc = '0;
        for (int i = 0; i < NV; i++) begin
            logic [13:0] elen;
            nxt_bytes = VEC[i][26:13];
            nxt_eop   = VEC[i][27];
            wait_start();
            check("R2 mover buffer pointer", mv_addr, 32'h1000 + (i % 4) * 32'h800);
            check("R2 mover size", 32'(mv_size), 32'(VEC[i][12:0]));
            check("R3 running state_code", 32'(state_code), 32'd2);
            wait_wb();
            check("R3 writeback address follows chain", mem_addr, RING[i % 4]);
            elen = VEC[i][27] ? acc + VEC[i][26:13] : 14'd0;
            check("R6 R7 status word", mem_wdata, status(first, VEC[i][27], elen));
            first = VEC[i][27];
            acc = VEC[i][27] ? 14'd0 : acc + VEC[i][26:13];
            @(negedge clk);
            check("R8 completion pulse", 32'(done_irq), 32'(!VEC[i][28]));
            if (i < 2) arm(i, VEC[i + 4][12:0], VEC[i + 4][28]);
        end
        // R4: descriptor at 0x50 is software-owned
        wait_rd();
        check("R3 next read via pointer", mem_addr, 32'h50);
        @(negedge clk);
        check("R4 parked state_code", 32'(state_code), 32'd3);
        repeat (10) @(negedge clk);
        check("R4 no request while parked", 32'(mem_req), 32'd0);
        check("R4 no mover start", 32'(mv_starts), 32'd6);
        // R5: poll with ownership still clear
        kick();
        check("R5 poll refetch state_code", 32'(state_code), 32'd1);
        check("R5 poll refetch address", mem_addr, 32'h50);
        repeat (10) @(negedge clk);
        check("R5 parks again", 32'(state_code), 32'd3);
        check("R5 no mover start", 32'(mv_starts), 32'd6);
        // R5: poll after rearming
        arm(2, 13'd300, 1'b0);
        nxt_bytes = 14'd80; nxt_eop = 1'b1;
        @(negedge clk);
        kick();
        wait_start();
        check("R5 resumed buffer pointer", mv_addr, 32'h2000);
        check("R5 resumed size", 32'(mv_size), 32'd300);
        wait_wb();
        check("R6 single buffer status", mem_wdata, status(1'b1, 1'b1, 14'd80));
        @(negedge clk);
        check("R8 completion pulse after resume", 32'(done_irq), 32'd1);
        // R9: stop with a buffer in flight
        do @(negedge clk); while (state_code != 2'd3);
        arm(3, 13'd64, 1'b0);
        arm(0, 13'd64, 1'b0);
        nxt_bytes = 14'd40; nxt_eop = 1'b1;
        @(negedge clk);
        kick();
        wait_start();
        check("R9 in-flight buffer pointer", mv_addr, 32'h2800);
        run_en = 1'b0;
        wait_wb();
        check("R9 in-flight descriptor written", mem_wdata, status(1'b1, 1'b1, 14'd40));
        @(negedge clk);
        check("R9 stopped after writeback", 32'(state_code), 32'd0);
        repeat (10) @(negedge clk);
        check("R9 no request after stop", 32'(mem_req), 32'd0);
        check("R9 no further mover start", 32'(mv_starts), 32'd8);
        // R1: restart reloads from a new base
        base_addr = 32'h50;
        run_en = 1'b1;
        @(negedge clk);
        check("R1 restart state_code", 32'(state_code), 32'd1);
        check("R1 restart at new base", mem_addr, 32'h50);
        do @(negedge clk); while (state_code == 2'd1);
        check("R4 parked on restart", 32'(state_code), 32'd3);
        // R10: stop while parked
        run_en = 1'b0;
        @(negedge clk);
        check("R10 stop from park", 32'(state_code), 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule